// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers reset requests from four places and turns them into one clean internal reset for the processor core, the pins and the peripheral registers. The four sources are an active-low external reset pin, a brown-out detector flag, a software reset request bit and a watchdog underflow pulse. The asynchronous inputs pass through two-flop synchronisers. Once the last request has gone away, the internal reset stays asserted for a fixed number of clock cycles. On release, the block raises a one-cycle request to fetch the reset vector.

Each reset is either full or partial. The pin and the brown-out detector cause a full reset, which also clears a protected group: the two-bit processor-mode field and the watchdog reset-select bit. A software or watchdog reset is partial, so the protected group keeps its value. Two outputs carry this: `sysResetN`, which resets everything outside the protected group, and `protResetN`, which resets the protected group itself.

A cause register shows why the system was last reset. A software reset is accepted only while the main clock drives the CPU and is stable. A watchdog underflow raises an interrupt pulse instead of a reset when reset-select is 0.

Top module: `reset_hub`

## Requirements
- R1: While `pinResetN` is low, `sysResetN` and `protResetN` are low without waiting for a clock edge, `resetCause` reads 4'b0001, and `procMode` and `ctrlBits` read 0.
- R2: After `pinResetN` rises, `sysResetN` rises at the 18th rising clock edge: 2 synchroniser edges plus 16 hold edges. For a synchronous request sampled at edge k, with no later request, `sysResetN` rises at edge k+16.
- R3: A brown-out flag (`brownOutDet`=1) causes a full reset only while the enable bit `ctrlBits[2]` is 1. The reset is sampled on the 3rd rising edge after the flag rises and lasts until 18 edges after the flag falls. It clears `procMode` and `ctrlBits[1]`, keeps `ctrlBits[2]`, and sets `resetCause` to 4'b0010. With the enable bit at 0 the flag has no effect.
- R4: A configuration write with `cfgData[0]`=1 sets the software request bit only while `mainClkSel` and `mainClkStable` are both 1. Otherwise `ctrlBits[0]` stays 0 and no reset occurs. An accepted request gives a partial reset (`protResetN` stays high and `procMode` is kept) one edge after the write.
- R5: When `wdtUnderflow` is 1 and `ctrlBits[1]`=1, a partial reset starts at that edge. When `ctrlBits[1]`=0, the underflow instead gives a one-cycle `wdtIrq` pulse in the next cycle and no reset.
- R6: The software request bit `ctrlBits[0]` reads 1 for exactly one cycle and clears itself at the edge where the internal reset asserts.
- R7: If several requests arrive at the same edge, the priority is pin, brown-out, watchdog, software. `resetCause` records only the winner. If any full request takes part, the reset is full.
- R8: `vectorFetch` is high for exactly one cycle: the first cycle in which `sysResetN` is high.
- R9: `cfgWe` and `modeWe` writes are ignored while `sysResetN` is low.
- R10: The `resetCause` bits are bit0 pin, bit1 brown-out, bit2 watchdog and bit3 software. A full reset replaces the register with its own bit. A partial reset ORs its bit into the current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pinResetN | input | 1 | External reset pin, active low, asynchronous |
| brownOutDet | input | 1 | Brown-out detector flag, asynchronous |
| wdtUnderflow | input | 1 | Watchdog underflow pulse, synchronous |
| mainClkSel | input | 1 | Main clock is the CPU clock |
| mainClkStable | input | 1 | Main clock oscillation is stable |
| cfgWe | input | 1 | Write strobe for the control bits |
| cfgData | input | 3 | Control write data: bit0 software request, bit1 watchdog reset-select, bit2 brown-out enable |
| modeWe | input | 1 | Write strobe for the processor-mode field |
| modeData | input | MODE_W | Processor-mode write data |
| sysResetN | output | 1 | Internal reset for CPU, pins and unprotected registers, active low |
| protResetN | output | 1 | Reset for the protected register group, active low, asserted only on full resets |
| vectorFetch | output | 1 | One-cycle reset-vector fetch request |
| wdtIrq | output | 1 | Watchdog interrupt pulse |
| ctrlBits | output | 3 | Readback of the control bits |
| procMode | output | MODE_W | Processor-mode field |
| resetCause | output | 4 | Reset-cause register |

## Verification
The bench counts release edges after the pin, a brown-out pulse, and software and watchdog requests. A stretch counter that is off by one, or a synchroniser with a missing stage, shifts the count from 18 or 16. It makes watchdog and software requests meet at the same edge, and brown-out and software requests meet at the same edge. A wrong priority order records the wrong cause bit, and a design that lets the partial type win would keep the processor mode through a brown-out. It writes the software bit with the main clock deselected or unstable, and writes the mode field during a reset. A design that failed to block either write would reset when it should not, or would show a changed mode after release. Random runs of software, watchdog and mode operations check that partial causes build up and that full causes replace.

// File: rtl/reset_hub_pkg.sv
package reset_hub_pkg;
  localparam int CAUSE_W = 4;
  localparam int C_PIN = 0;
  localparam int C_BOD = 1;
  localparam int C_WDT = 2;
  localparam int C_SW  = 3;

  typedef struct packed {
    logic pin;
    logic bod;
    logic wdt;
    logic sw;
  } resetReq_t;

  typedef struct packed {
    logic               clearSw;
    logic               clearProt;
    logic               blockWr;
    logic               causeLoad;
    logic               causeReplace;
    logic [CAUSE_W-1:0] causeBit;
  } ctrlStrobe_t;
endpackage

// File: rtl/reset_hub_sync.sv
module reset_hub_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/reset_hub_dp.sv
module reset_hub_dp
  import reset_hub_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MODE_W      = 2
) (
  input  logic               clk,
  input  logic               pinResetN,
  input  logic               brownOutDet,
  input  logic               wdtUnderflow,
  input  logic               mainClkSel,
  input  logic               mainClkStable,
  input  logic               cfgWe,
  input  logic [2:0]         cfgData,
  input  logic               modeWe,
  input  logic [MODE_W-1:0]  modeData,
  input  ctrlStrobe_t        strobe,
  output resetReq_t          req,
  output logic [2:0]         ctrlBits,
  output logic [MODE_W-1:0]  procMode,
  output logic [CAUSE_W-1:0] resetCause,
  output logic               wdtIrq
);
  logic pinSyncQ;
  logic bodSyncQ;
  logic swBit;
  logic wdtSel;
  logic bodEn;
  logic [MODE_W-1:0] modeReg;
  logic [CAUSE_W-1:0] causeReg;
  logic irqReg;
  logic wrOk;
  logic swAllowed;

  reset_hub_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_pinSync (
    .clk(clk), .rstN(pinResetN), .d(1'b1), .q(pinSyncQ)
  );

  reset_hub_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_bodSync (
    .clk(clk), .rstN(pinResetN), .d(brownOutDet), .q(bodSyncQ)
  );

  assign wrOk      = !strobe.blockWr;
  assign swAllowed = mainClkSel & mainClkStable;

  always_ff @(posedge clk or negedge pinResetN) begin
    if (!pinResetN) begin
      swBit    <= 1'b0;
      wdtSel   <= 1'b0;
      bodEn    <= 1'b0;
      modeReg  <= '0;
      causeReg <= CAUSE_W'(1) << C_PIN;
      irqReg   <= 1'b0;
    end else begin
      irqReg <= wdtUnderflow & ~wdtSel;

      if (strobe.clearSw)
        swBit <= 1'b0;
      else if (cfgWe && wrOk)
        swBit <= cfgData[0] & swAllowed;

      if (strobe.clearProt) begin
        wdtSel  <= 1'b0;
        modeReg <= '0;
      end else if (wrOk) begin
        if (cfgWe)  wdtSel  <= cfgData[1];
        if (modeWe) modeReg <= modeData;
      end

      if (cfgWe && wrOk)
        bodEn <= cfgData[2];

      if (strobe.causeLoad)
        causeReg <= strobe.causeReplace ? strobe.causeBit
                                        : (causeReg | strobe.causeBit);
    end
  end

  assign req.pin    = ~pinSyncQ;
  assign req.bod    = bodSyncQ & bodEn;
  assign req.wdt    = wdtUnderflow & wdtSel;
  assign req.sw     = swBit;

  assign ctrlBits   = {bodEn, wdtSel, swBit};
  assign procMode   = modeReg;
  assign resetCause = causeReg;
  assign wdtIrq     = irqReg;
endmodule

// File: rtl/reset_hub_ctrl.sv
module reset_hub_ctrl
  import reset_hub_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic        clk,
  input  logic        pinResetN,
  input  resetReq_t   req,
  output ctrlStrobe_t strobe,
  output logic        sysResetN,
  output logic        protResetN,
  output logic        vectorFetch
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

  logic             inReset;
  logic             fullKind;
  logic [CNT_W-1:0] holdCnt;
  logic             vecQ;
  logic             anyReq;
  logic             fullReq;
  logic [CAUSE_W-1:0] winner;

  assign anyReq  = req.pin | req.bod | req.wdt | req.sw;
  assign fullReq = req.pin | req.bod;

  always_comb begin
    winner = '0;
    if (req.pin)      winner[C_PIN] = 1'b1;
    else if (req.bod) winner[C_BOD] = 1'b1;
    else if (req.wdt) winner[C_WDT] = 1'b1;
    else if (req.sw)  winner[C_SW]  = 1'b1;
  end

  always_comb begin
    strobe.clearSw      = anyReq;
    strobe.clearProt    = fullReq | (inReset & fullKind);
    strobe.blockWr      = inReset | anyReq;
    strobe.causeLoad    = anyReq;
    strobe.causeReplace = fullReq;
    strobe.causeBit     = winner;
  end

  always_ff @(posedge clk or negedge pinResetN) begin
    if (!pinResetN) begin
      inReset  <= 1'b1;
      fullKind <= 1'b1;
      holdCnt  <= CNT_W'(HOLD_CYCLES);
      vecQ     <= 1'b0;
    end else begin
      vecQ <= 1'b0;
      if (anyReq) begin
        inReset  <= 1'b1;
        holdCnt  <= CNT_W'(HOLD_CYCLES);
        fullKind <= fullReq | (inReset & fullKind);
      end else if (inReset) begin
        if (holdCnt == CNT_W'(1)) begin
          inReset  <= 1'b0;
          fullKind <= 1'b0;
          vecQ     <= 1'b1;
        end else begin
          holdCnt <= holdCnt - CNT_W'(1);
        end
      end
    end
  end

  assign sysResetN   = ~inReset;
  assign protResetN  = ~(inReset & fullKind);
  assign vectorFetch = vecQ;
endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import reset_hub_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_W      = 2
) (
  input  logic               clk,
  input  logic               pinResetN,
  input  logic               brownOutDet,
  input  logic               wdtUnderflow,
  input  logic               mainClkSel,
  input  logic               mainClkStable,
  input  logic               cfgWe,
  input  logic [2:0]         cfgData,
  input  logic               modeWe,
  input  logic [MODE_W-1:0]  modeData,
  output logic               sysResetN,
  output logic               protResetN,
  output logic               vectorFetch,
  output logic               wdtIrq,
  output logic [2:0]         ctrlBits,
  output logic [MODE_W-1:0]  procMode,
  output logic [CAUSE_W-1:0] resetCause
);
  ctrlStrobe_t strobe;
  resetReq_t   req;

  reset_hub_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk(clk), .pinResetN(pinResetN), .req(req), .strobe(strobe),
    .sysResetN(sysResetN), .protResetN(protResetN), .vectorFetch(vectorFetch)
  );

  reset_hub_dp #(.SYNC_STAGES(SYNC_STAGES), .MODE_W(MODE_W)) u_dp (
    .clk(clk), .pinResetN(pinResetN), .brownOutDet(brownOutDet),
    .wdtUnderflow(wdtUnderflow), .mainClkSel(mainClkSel),
    .mainClkStable(mainClkStable), .cfgWe(cfgWe), .cfgData(cfgData),
    .modeWe(modeWe), .modeData(modeData), .strobe(strobe), .req(req),
    .ctrlBits(ctrlBits), .procMode(procMode), .resetCause(resetCause),
    .wdtIrq(wdtIrq)
  );
endmodule

// File: rtl/reset_hub_chk.sv
module reset_hub_chk #(
  parameter int HOLD_CYCLES = 16,
  parameter int MODE_W      = 2
) (
  input logic              clk,
  input logic              pinResetN,
  input logic              sysResetN,
  input logic              protResetN,
  input logic              vectorFetch,
  input logic              wdtUnderflow,
  input logic              wdtIrq,
  input logic [2:0]        ctrlBits,
  input logic              modeWe,
  input logic [MODE_W-1:0] procMode
);
  localparam int RUN_W = $clog2(HOLD_CYCLES + 2) + 1;
  logic [RUN_W-1:0] lowRun;

  always_ff @(posedge clk or negedge pinResetN) begin
    if (!pinResetN)
      lowRun <= '0;
    else if (!sysResetN) begin
      if (lowRun != {RUN_W{1'b1}}) lowRun <= lowRun + RUN_W'(1);
    end else
      lowRun <= '0;
  end

  a_r1_prot_inside_sys: assert property (@(posedge clk) disable iff (!pinResetN)
    !protResetN |-> !sysResetN);

  a_r2_min_hold: assert property (@(posedge clk) disable iff (!pinResetN)
    $rose(sysResetN) |-> (lowRun >= RUN_W'(HOLD_CYCLES)));

  a_r4_mode_kept: assert property (@(posedge clk) disable iff (!pinResetN)
    ($past(protResetN) && protResetN && !$past(modeWe)) |-> $stable(procMode));

  a_r5_irq_source: assert property (@(posedge clk) disable iff (!pinResetN)
    wdtIrq |-> ($past(wdtUnderflow) && !$past(ctrlBits[1])));

  a_r6_sw_self_clear: assert property (@(posedge clk) disable iff (!pinResetN)
    ctrlBits[0] |=> !ctrlBits[0]);

  a_r8_vector_on_release: assert property (@(posedge clk) disable iff (!pinResetN)
    $rose(sysResetN) |-> vectorFetch);

  a_r8_vector_single: assert property (@(posedge clk) disable iff (!pinResetN)
    vectorFetch |=> !vectorFetch);
endmodule

bind reset_hub reset_hub_chk #(.HOLD_CYCLES(HOLD_CYCLES), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .pinResetN(pinResetN), .sysResetN(sysResetN),
  .protResetN(protResetN), .vectorFetch(vectorFetch),
  .wdtUnderflow(wdtUnderflow), .wdtIrq(wdtIrq), .ctrlBits(ctrlBits),
  .modeWe(modeWe), .procMode(procMode)
);

// File: tb/reset_hub_bench.sv
`timescale 1ns/1ps
module reset_hub_bench;
  logic clk = 1'b0;
  logic pinResetN = 1'b0;
  logic brownOutDet = 1'b0;
  logic wdtUnderflow = 1'b0;
  logic mainClkSel = 1'b1;
  logic mainClkStable = 1'b1;
  logic cfgWe = 1'b0;
  logic [2:0] cfgData = 3'b000;
  logic modeWe = 1'b0;
  logic [1:0] modeData = 2'b00;
  logic sysResetN, protResetN, vectorFetch, wdtIrq;
  logic [2:0] ctrlBits;
  logic [1:0] procMode;
  logic [3:0] resetCause;

  int checks = 0;
  int errors = 0;
  logic [3:0] expCause;
  logic [1:0] expMode;
  logic expSel, expEn;
  int n;

  reset_hub u_reset_hub (
    .clk(clk), .pinResetN(pinResetN), .brownOutDet(brownOutDet),
    .wdtUnderflow(wdtUnderflow), .mainClkSel(mainClkSel),
    .mainClkStable(mainClkStable), .cfgWe(cfgWe), .cfgData(cfgData),
    .modeWe(modeWe), .modeData(modeData), .sysResetN(sysResetN),
    .protResetN(protResetN), .vectorFetch(vectorFetch), .wdtIrq(wdtIrq),
    .ctrlBits(ctrlBits), .procMode(procMode), .resetCause(resetCause)
  );

  always #5 clk = ~clk;

  function automatic logic [3:0] causeAfter(input logic [3:0] cur, input int src, input bit full);
    logic [3:0] b;
    b = 4'b0001 << src;
    return full ? b : (cur | b);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input bit sw);
    cfgData = {expEn, expSel, sw};
    cfgWe = 1'b1;
    step();
    cfgWe = 1'b0;
  endtask

  task automatic countRelease(output int cnt);
    cnt = 0;
    while (!sysResetN && cnt < 100) begin
      step();
      cnt++;
    end
  endtask

  task automatic checkState(input string tag);
    checkEq({tag, " cause"}, resetCause, expCause);
    checkEq({tag, " mode"}, procMode, expMode);
    checkEq({tag, " ctrl"}, ctrlBits, {expEn, expSel, 1'b0});
  endtask

  task automatic pinReset();
    pinResetN = 1'b0;
    #3;
    checkEq("R1 sys async", sysResetN, 0);
    checkEq("R1 prot async", protResetN, 0);
    checkEq("R1 cause", resetCause, 4'b0001);
    checkEq("R1 mode", procMode, 0);
    checkEq("R1 ctrl", ctrlBits, 0);
    step(); step();
    pinResetN = 1'b1;
    expCause = 4'b0001; expMode = 2'b00; expSel = 1'b0; expEn = 1'b0;
    countRelease(n);
    checkEq("R2 pin release edges", n, 18);
    checkEq("R8 vector pulse", vectorFetch, 1);
    step();
    checkEq("R8 vector single", vectorFetch, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step();
    pinReset();

    // R9 mode write outside reset
    modeData = 2'b10; modeWe = 1'b1; step(); modeWe = 1'b0;
    expMode = 2'b10;
    checkEq("R9 mode write", procMode, 2);

    // R4 ignored software request: clock not selected, then not stable
    mainClkSel = 1'b0;
    cfgWrite(1'b1);
    checkEq("R4 sw ignored sel", ctrlBits[0], 0);
    step(); step();
    checkEq("R4 no reset sel", sysResetN, 1);
    mainClkSel = 1'b1; mainClkStable = 1'b0;
    cfgWrite(1'b1);
    checkEq("R4 sw ignored stable", ctrlBits[0], 0);
    step(); step();
    checkEq("R4 no reset stable", sysResetN, 1);
    mainClkStable = 1'b1;

    // R4 R6 R9 R10 accepted software reset
    cfgWrite(1'b1);
    checkEq("R6 sw bit set", ctrlBits[0], 1);
    checkEq("R4 not yet reset", sysResetN, 1);
    step();
    checkEq("R4 sw reset", sysResetN, 0);
    checkEq("R4 partial", protResetN, 1);
    checkEq("R6 sw self clear", ctrlBits[0], 0);
    modeData = 2'b01; modeWe = 1'b1; step(); modeWe = 1'b0;
    countRelease(n);
    checkEq("R2 sw release edges", n + 1, 16);
    expCause = causeAfter(expCause, 3, 0);
    checkState("R10 R9 after sw");

    // R5 interrupt instead of reset
    wdtUnderflow = 1'b1; step(); wdtUnderflow = 1'b0;
    checkEq("R5 irq pulse", wdtIrq, 1);
    checkEq("R5 no reset", sysResetN, 1);
    step();
    checkEq("R5 irq one cycle", wdtIrq, 0);

    // R5 watchdog reset
    expSel = 1'b1; cfgWrite(1'b0);
    wdtUnderflow = 1'b1; step(); wdtUnderflow = 1'b0;
    checkEq("R5 wdt reset", sysResetN, 0);
    checkEq("R5 partial", protResetN, 1);
    countRelease(n);
    checkEq("R2 wdt release edges", n, 16);
    expCause = causeAfter(expCause, 2, 0);
    checkState("R10 after wdt");

    // R3 brown-out disabled
    brownOutDet = 1'b1;
    repeat (5) step();
    checkEq("R3 bod disabled", sysResetN, 1);
    brownOutDet = 1'b0;
    repeat (3) step();

    // R3 brown-out enabled
    expEn = 1'b1; cfgWrite(1'b0);
    brownOutDet = 1'b1;
    step(); step();
    checkEq("R3 bod sync delay", sysResetN, 1);
    step();
    checkEq("R3 bod reset", sysResetN, 0);
    checkEq("R3 bod full", protResetN, 0);
    repeat (4) step();
    brownOutDet = 1'b0;
    countRelease(n);
    checkEq("R3 bod release edges", n, 18);
    expCause = 4'b0010; expMode = 2'b00; expSel = 1'b0;
    checkState("R3 after bod");

    // R7 watchdog and software at the same edge
    expSel = 1'b1; cfgWrite(1'b0);
    modeData = 2'b11; modeWe = 1'b1; step(); modeWe = 1'b0; expMode = 2'b11;
    cfgWrite(1'b1);
    wdtUnderflow = 1'b1; step(); wdtUnderflow = 1'b0;
    checkEq("R7 wdt+sw reset", sysResetN, 0);
    countRelease(n);
    checkEq("R7 release edges", n, 16);
    expCause = causeAfter(expCause, 2, 0);
    checkState("R7 wdt wins");

    // R7 brown-out and software at the same edge
    brownOutDet = 1'b1;
    step();
    cfgWrite(1'b1);
    step();
    checkEq("R7 full wins", protResetN, 0);
    brownOutDet = 1'b0;
    countRelease(n);
    checkEq("R7 bod release", n, 18);
    expCause = 4'b0010; expMode = 2'b00; expSel = 1'b0;
    checkState("R7 bod wins");

    // random mix of partial operations
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 40; i++) begin
      int op;
      op = $urandom % 3;
      if (op == 0) begin
        bit cs, st;
        cs = $urandom % 2; st = $urandom % 2;
        mainClkSel = cs; mainClkStable = st;
        cfgWrite(1'b1);
        mainClkSel = 1'b1; mainClkStable = 1'b1;
        step();
        if (cs && st) begin
          checkEq("R4 rnd sw reset", sysResetN, 0);
          countRelease(n);
          checkEq("R2 rnd sw edges", n, 16);
          expCause = causeAfter(expCause, 3, 0);
        end else begin
          checkEq("R4 rnd sw ignored", sysResetN, 1);
        end
      end else if (op == 1) begin
        expSel = $urandom % 2;
        cfgWrite(1'b0);
        wdtUnderflow = 1'b1; step(); wdtUnderflow = 1'b0;
        if (expSel) begin
          checkEq("R5 rnd wdt reset", sysResetN, 0);
          countRelease(n);
          checkEq("R2 rnd wdt edges", n, 16);
          expCause = causeAfter(expCause, 2, 0);
        end else begin
          checkEq("R5 rnd irq", wdtIrq, 1);
          step();
        end
      end else begin
        expMode = 2'($urandom);
        modeData = expMode; modeWe = 1'b1; step(); modeWe = 1'b0;
      end
      checkState("R10 rnd");
    end

    pinReset();
    checkState("R1 final");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule